// File: doc/BRIEF.md
# First-Come-First-Served Resource Arbiter

This block shares one resource among N requesters and serves them strictly in the order in which their requests were first seen. A requester raises its request line and holds it high for as long as it needs the resource. The arbiter answers with a one-hot grant. Requesters that arrive while the resource is busy are recorded as indices in an internal queue, and each index is added only once.

When the owner lowers its request, the grant drops and a notification output pulses high for a fixed number of cycles. After that, the arbiter waits for a completion input before it issues the next grant. Queued requesters whose request has already gone low by the time they reach the head are discarded without being granted. There is no time limit on a grant and no preemption.

Top module: `fcfs_arbiter`

## Requirements
- R1: When the resource is free and the queue is empty, a newly raised request is granted on the first clock edge that samples it. If several requests appear together, the lowest index is granted and the rest are queued.
- R2: Grants are issued in the order in which requests were first sampled. Requests that first appear on the same edge are queued in ascending index order.
- R3: Bit i of `grant` belongs to requester i, and at most one bit of `grant` is set at any time.
- R4: A grant is only issued to a requester whose request was high on the issuing edge. It stays asserted for as long as that request stays high, with no time limit.
- R5: `grant` clears on the edge that samples the owner's request low. `notify` rises on that same edge and stays high for exactly PULSE_LEN cycles (default 3).
- R6: No grant is issued while `notify` is high. After `notify` falls, no grant is issued until `done` is sampled high. The next grant can appear on the edge after that sample. A high `done` during the pulse has no effect.
- R7: A requester that is already queued or granted is not queued a second time, even if its request toggles while it waits.
- R8: A queued requester whose request is low when it reaches the queue head is removed without a grant. Each such removal takes one cycle.
- R9: A synchronous reset clears the grant, the notification output and the queue.
- R10: The requester count is the parameter N (default 8) and scales to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N | Request lines, one per requester, held high while service is needed |
| done | input | 1 | Completion handshake; it allows the next grant once the notification pulse has ended |
| grant | output | N | One-hot grant vector |
| notify | output | 1 | High for PULSE_LEN cycles after a grant is released |

## Verification
A four-requester instance is driven with every non-empty set of simultaneous arrivals. This checks that the immediate grant goes to the lowest index and that the remaining requesters follow in ascending order. Staggered arrivals out of index order separate arrival-order service from any priority scheme.

Further sequences cover the following cases:
- a request toggled while queued, which shows up as a duplicate grant if the once-only flag is broken;
- a request dropped while queued, which shows the skip and its extra cycle;
- holding `done` low, which shows the completion gate;
- a reset applied while entries are queued.

A 64-requester instance checks that high indices are queued and served in the correct order.

// File: rtl/fcfs_arbiter.sv
module fcfs_arbiter #(
  parameter int N         = 8,
  parameter int PULSE_LEN = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         done,
  output logic [N-1:0] grant,
  output logic         notify
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);
  localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  typedef enum logic [1:0] {S_FREE, S_HELD, S_NOTE, S_WAIT} st_t;

  st_t           st, st_n;
  logic [IW-1:0] slot   [N];
  logic [IW-1:0] slot_n [N];
  logic [IW-1:0] rd_p, rd_n, wr_p, wr_n, own, own_n, head, low;
  logic [CW-1:0] cnt, cnt_n;
  logic [PW-1:0] pc, pc_n;
  logic [N-1:0]  seen, seen_n, fresh, enq, grant_n;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fresh  = req & ~seen;
  assign head   = slot[rd_p];
  assign notify = (st == S_NOTE);

  always_comb begin
    low = '0;
    for (int i = N - 1; i >= 0; i--)
      if (fresh[i]) low = IW'(i);
  end

  always_comb begin
    st_n    = st;
    slot_n  = slot;
    rd_n    = rd_p;
    wr_n    = wr_p;
    cnt_n   = cnt;
    own_n   = own;
    pc_n    = pc;
    seen_n  = seen;
    grant_n = grant;
    enq     = fresh;
    case (st)
      S_FREE: begin
        if (cnt != '0) begin
          rd_n  = bump(rd_p);
          cnt_n = cnt - 1'b1;
          if (req[head]) begin
            grant_n       = '0;
            grant_n[head] = 1'b1;
            own_n         = head;
            st_n          = S_HELD;
          end else begin
            seen_n[head] = 1'b0;
          end
        end else if (fresh != '0) begin
          grant_n      = '0;
          grant_n[low] = 1'b1;
          own_n        = low;
          seen_n[low]  = 1'b1;
          enq[low]     = 1'b0;
          st_n         = S_HELD;
        end
      end
      S_HELD: begin
        if (!req[own]) begin
          grant_n     = '0;
          seen_n[own] = 1'b0;
          pc_n        = '0;
          st_n        = S_NOTE;
        end
      end
      S_NOTE: begin
        if (pc == PW'(PULSE_LEN - 1)) st_n = S_WAIT;
        else pc_n = pc + 1'b1;
      end
      default: begin
        if (done) st_n = S_FREE;
      end
    endcase
    for (int i = 0; i < N; i++) begin
      if (enq[i]) begin
        slot_n[wr_n] = IW'(i);
        wr_n         = bump(wr_n);
        cnt_n        = cnt_n + 1'b1;
        seen_n[i]    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    slot <= slot_n;
    if (rst) begin
      st    <= S_FREE;
      rd_p  <= '0;
      wr_p  <= '0;
      cnt   <= '0;
      own   <= '0;
      pc    <= '0;
      seen  <= '0;
      grant <= '0;
    end else begin
      st    <= st_n;
      rd_p  <= rd_n;
      wr_p  <= wr_n;
      cnt   <= cnt_n;
      own   <= own_n;
      pc    <= pc_n;
      seen  <= seen_n;
      grant <= grant_n;
    end
  end
endmodule

// File: rtl/fcfs_arbiter_chk.sv
module fcfs_arbiter_chk #(
  parameter int N         = 8,
  parameter int PULSE_LEN = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic         done,
  input logic [N-1:0] grant,
  input logic         notify
);
  logic [7:0] run;
  logic       gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      gate <= 1'b0;
    end else begin
      run <= notify ? run + 1'b1 : '0;
      if (notify) gate <= 1'b1;
      else if (done) gate <= 1'b0;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R3
  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && $past(grant) == '0) |-> ((grant & $past(req)) != '0)); // R4
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (grant & req) != '0) |=> $stable(grant)); // R4
  AST_RELEASE_NOTIFY: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && (grant & req) == '0) |=> (notify && grant == '0)); // R5
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(notify) |-> (run == 8'(PULSE_LEN))); // R5
  AST_QUIET_DURING_NOTIFY: assert property (@(posedge clk) disable iff (rst)
    notify |-> (grant == '0)); // R6
  AST_DONE_GATE: assert property (@(posedge clk) disable iff (rst)
    (gate && !notify && !done) |=> (grant == '0)); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (grant == '0 && !notify)); // R9
endmodule

bind fcfs_arbiter fcfs_arbiter_chk #(.N(N), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .req(req), .done(done), .grant(grant), .notify(notify)
);

// File: tb/fcfs_arbiter_tb.sv
module fcfs_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done = 1'b1;
  logic [3:0]  req = '0;
  logic [3:0]  grant;
  logic        notify;
  logic [63:0] req_w = '0;
  logic [63:0] grant_w;
  logic        notify_w;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fcfs_arbiter #(.N(4), .PULSE_LEN(3)) u_dut (
    .clk(clk), .rst(rst), .req(req), .done(done), .grant(grant), .notify(notify));
  fcfs_arbiter #(.N(64), .PULSE_LEN(3)) u_wide (
    .clk(clk), .rst(rst), .req(req_w), .done(done), .grant(grant_w), .notify(notify_w));

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_to(input int idx, input int nxt, input bit has_nxt, input int skips);
    req[idx] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R5 notify high", 64'(notify), 64'd1);
      chk("R6 no grant during notify", 64'(grant), 64'd0);
    end
    step();
    chk("R5 notify ends", 64'(notify), 64'd0);
    chk("R6 no grant before done", 64'(grant), 64'd0);
    for (int k = 0; k < 1 + skips; k++) begin
      step();
      chk("R8 gap cycle", 64'(grant), 64'd0);
    end
    step();
    chk("R2 next grant", 64'(grant), has_nxt ? (64'd1 << nxt) : 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) step();
    chk("R9 reset grant", 64'(grant), 64'd0);
    chk("R9 reset notify", 64'(notify), 64'd0);
    rst = 1'b0;
    step();

    // R1 R2: every simultaneous arrival pattern, lowest first then ascending
    for (int p = 1; p < 16; p++) begin
      int cur;
      int first;
      first = 0;
      for (int b = 3; b >= 0; b--) if (p[b]) first = b;
      req = 4'(p);
      step();
      chk("R1 immediate grant lowest", 64'(grant), 64'd1 << first);
      cur = first;
      for (int b = first + 1; b < 4; b++) begin
        if (p[b]) begin
          release_to(cur, b, 1'b1, 0);
          cur = b;
        end
      end
      release_to(cur, 0, 1'b0, 0);
    end

    // R2: arrival order differs from index order
    req[2] = 1'b1; step();
    chk("R1 single grant", 64'(grant), 64'd4);
    req[3] = 1'b1; step();
    req[0] = 1'b1; step();
    req[1] = 1'b1; step();
    release_to(2, 3, 1'b1, 0);
    release_to(3, 0, 1'b1, 0);
    release_to(0, 1, 1'b1, 0);
    release_to(1, 0, 1'b0, 0);

    // R6: done gate
    req[1] = 1'b1; step();
    chk("R1 grant before gate test", 64'(grant), 64'd2);
    req[0] = 1'b1; step();
    done = 1'b0;
    req[1] = 1'b0;
    for (int k = 0; k < 13; k++) begin
      step();
      chk("R6 held off without done", 64'(grant), 64'd0);
    end
    done = 1'b1;
    step();
    chk("R6 free after done", 64'(grant), 64'd0);
    step();
    chk("R6 grant after done", 64'(grant), 64'd1);
    release_to(0, 0, 1'b0, 0);

    // R7: toggling while queued adds no second entry
    req[0] = 1'b1; step();
    req[1] = 1'b1; step();
    req[1] = 1'b0; step();
    req[1] = 1'b1; step();
    req[2] = 1'b1; step();
    release_to(0, 1, 1'b1, 0);
    release_to(1, 2, 1'b1, 0);
    release_to(2, 0, 1'b0, 0);
    chk("R7 no duplicate grant", 64'(grant), 64'd0);

    // R8: dropped request skipped at head
    req[0] = 1'b1; step();
    req[1] = 1'b1; req[2] = 1'b1; step();
    req[1] = 1'b0; step();
    release_to(0, 2, 1'b1, 1);
    release_to(2, 0, 1'b0, 0);

    // R4: long hold, no timeout
    req[3] = 1'b1; step();
    for (int k = 0; k < 40; k++) begin
      step();
      chk("R4 grant held", 64'(grant), 64'd8);
    end
    release_to(3, 0, 1'b0, 0);

    // R9: reset empties the queue
    req = 4'b0011; step();
    chk("R1 grant before reset", 64'(grant), 64'd1);
    rst = 1'b1; req = '0;
    step(); step();
    chk("R9 grant cleared", 64'(grant), 64'd0);
    chk("R9 notify cleared", 64'(notify), 64'd0);
    rst = 1'b0; req[3] = 1'b1;
    step();
    chk("R9 queue emptied", 64'(grant), 64'd8);
    release_to(3, 0, 1'b0, 0);

    // R10: 64-requester instance
    req_w[63] = 1'b1; req_w[40] = 1'b1;
    step();
    chk("R10 wide immediate", grant_w, 64'd1 << 40);
    req_w[40] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R10 wide notify", 64'(notify_w), 64'd1);
    end
    step(); step(); step();
    chk("R10 wide queued grant", grant_w, 64'd1 << 63);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule